// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

The block holds four independent down-counters behind a 32-bit register port. Channels 0 and 1 keep 24-bit counts, channels 2 and 3 keep 32-bit counts. Each channel has a reload register and a live count register. One shared control word sets, for every channel, whether it runs, whether it is periodic or one-shot, and which tick it follows. One shared interrupt word holds a per-channel interrupt enable and a per-channel pending flag. The pending flags combine into a single interrupt line.

Software loads a count while the channel is stopped, picks a mode, and then sets the enable bit. A periodic channel reloads itself on every expiry and makes a steady event rate. A one-shot channel counts down once and then rests at zero. If a periodic channel is loaded with all ones and never interrupts, its count register can be read as a descending free-running time base.

Top module: `quad_dtimer`

## Requirements
- R1: After reset, every mapped register reads zero and `irq_o` is low.
- R2: Byte addresses are: control 0x00, interrupt 0x04, reload of channel t at 0x10+4t, count of channel t at 0x20+4t. Channels 0 and 1 store 24 bits and read zero in bits 31:24. Channels 2 and 3 store 32 bits. Unmapped addresses read zero.
- R3: An enabled channel decrements once on each of its ticks. A disabled channel holds its count.
- R4: Control bit 2t+1 = 1 selects periodic mode. On a tick that finds the count at 1, the count loads the reload value and the channel expires. An enabled periodic channel that finds the count at 0 loads the reload value without expiring.
- R5: Control bit 2t+1 = 0 selects one-shot mode. On a tick that finds the count at 1, the count becomes 0 and the channel expires. It then stays at 0 while it remains enabled.
- R6: An expiry sets pending bit t+4 of the interrupt register on the same clock edge. If the same edge also carries a write that clears that bit, the set wins.
- R7: Writing 1 to pending bit t+4 clears it. Writing 0 there leaves it unchanged. Bits 3:0 of the same write load the interrupt enables.
- R8: `irq_o` is high exactly when some channel has both its pending bit and its enable bit (bit t) set.
- R9: A write to a count register takes effect only while that channel's enable (control bit 2t) is 0; while the channel is enabled the write is ignored. Reload registers accept writes at any time.
- R10: Control bit t+8 selects the tick. With 0 the channel steps every clock. With 1 it steps only on clocks where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe, one register per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | External tick used by channels whose source bit is 1 |
| irq_o | output | 1 | Combined interrupt |

## Verification
A channel's expiry and a software write of ones to the pending field can land on the same clock edge. Both act on the same pending bit. The bench forces this case with a periodic channel whose reload and count are 1, so the channel expires on every edge, and writes 0xF0 to the interrupt register on consecutive edges. It expects the pending bit still to read 1 after each write. Once the channel is stopped, one more clear must bring the bit to 0. A behavioural model compares the read data and the interrupt line on every clock, so a collision that comes up anywhere else in the run is also judged.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
    parameter int NCH       = 4;
    parameter int REG_W     = 32;
    parameter int NARROW_W  = 24;
    parameter int NARROW_CH = 2;
    parameter int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] ADDR_IRQ  = 8'h04;
    localparam logic [ADDR_W-1:0] ADDR_REL  = 8'h10;
    localparam logic [ADDR_W-1:0] ADDR_CNT  = 8'h20;
    localparam int PEND_LSB = 4;
    localparam int SRC_LSB  = 8;

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] mode;
        logic [NCH-1:0] src;
        logic [NCH-1:0] ie;
        logic [NCH-1:0] pend;
    } regs_t;
endpackage

// File: rtl/qdt_chan.sv
module qdt_chan #(
    parameter int W = 24
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic         mode_i,
    input  logic         step_i,
    input  logic         rel_we_i,
    input  logic         cnt_we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] rel_o,
    output logic         expire_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rel;
    } chan_t;

    chan_t d, q;

    always_comb begin
        d        = q;
        expire_o = 1'b0;
        if (en_i && step_i) begin
            if (q.cnt == W'(1)) begin
                expire_o = 1'b1;
                d.cnt    = mode_i ? q.rel : '0;
            end else if (q.cnt == '0) begin
                if (mode_i) d.cnt = q.rel;
            end else begin
                d.cnt = q.cnt - W'(1);
            end
        end
        if (cnt_we_i && !en_i) d.cnt = wdata_i;
        if (rel_we_i)          d.rel = wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign cnt_o = q.cnt;
    assign rel_o = q.rel;

    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !cnt_we_i) |=> $stable(q.cnt));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !mode_i && q.cnt == '0 && !cnt_we_i) |=> (q.cnt == '0));

    // R4
    reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && mode_i && step_i && q.cnt == W'(1)) |=> (q.cnt == $past(q.rel)));
endmodule

// File: rtl/quad_dtimer.sv
module quad_dtimer
    import qdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              tick_i,
    output logic              irq_o
);
    regs_t d, q;

    logic [NCH-1:0]   expire;
    logic [NCH-1:0]   step;
    logic [NCH-1:0]   rel_we;
    logic [NCH-1:0]   cnt_we;
    logic [REG_W-1:0] cnt_x [NCH];
    logic [REG_W-1:0] rel_x [NCH];

    wire wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
    wire wr_irq  = wr_i && (addr_i == ADDR_IRQ);

    for (genvar t = 0; t < NCH; t++) begin : g_ch
        localparam int W = (t < NARROW_CH) ? NARROW_W : REG_W;
        logic [W-1:0] cnt_w, rel_w;

        assign step[t]   = q.src[t] ? tick_i : 1'b1;
        assign rel_we[t] = wr_i && (addr_i == ADDR_REL + ADDR_W'(4 * t));
        assign cnt_we[t] = wr_i && (addr_i == ADDR_CNT + ADDR_W'(4 * t));

        qdt_chan #(.W(W)) u_chan (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (q.en[t]),
            .mode_i   (q.mode[t]),
            .step_i   (step[t]),
            .rel_we_i (rel_we[t]),
            .cnt_we_i (cnt_we[t]),
            .wdata_i  (wdata_i[W-1:0]),
            .cnt_o    (cnt_w),
            .rel_o    (rel_w),
            .expire_o (expire[t])
        );

        assign cnt_x[t] = REG_W'(cnt_w);
        assign rel_x[t] = REG_W'(rel_w);

        // R6
        pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            expire[t] |=> q.pend[t]);

        // R7
        w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_irq && wdata_i[PEND_LSB + t] && !expire[t]) |=> !q.pend[t]);
    end

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            for (int t = 0; t < NCH; t++) begin
                d.en[t]   = wdata_i[2 * t];
                d.mode[t] = wdata_i[2 * t + 1];
                d.src[t]  = wdata_i[SRC_LSB + t];
            end
        end
        if (wr_irq) begin
            d.ie   = wdata_i[NCH-1:0];
            d.pend = q.pend & ~wdata_i[PEND_LSB +: NCH];
        end
        d.pend = d.pend | expire;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTRL) begin
            for (int t = 0; t < NCH; t++) begin
                rdata_o[2 * t]         = q.en[t];
                rdata_o[2 * t + 1]     = q.mode[t];
                rdata_o[SRC_LSB + t]   = q.src[t];
            end
        end else if (addr_i == ADDR_IRQ) begin
            rdata_o[NCH-1:0]          = q.ie;
            rdata_o[PEND_LSB +: NCH]  = q.pend;
        end
        for (int t = 0; t < NCH; t++) begin
            if (addr_i == ADDR_REL + ADDR_W'(4 * t)) rdata_o = rel_x[t];
            if (addr_i == ADDR_CNT + ADDR_W'(4 * t)) rdata_o = cnt_x[t];
        end
    end

    assign irq_o = |(q.pend & q.ie);

    // R8
    irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_irq && (&wdata_i[PEND_LSB +: NCH]) && expire == '0) |=> !irq_o);
endmodule

// File: tb/tb_quad_dtimer.sv
module tb_quad_dtimer;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  addr_i = 8'h00;
    logic        wr_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        tick_i = 1'b0;
    logic        irq_o;

    quad_dtimer dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i), .irq_o(irq_o)
    );

    always #10 clk_i = ~clk_i;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    longint unsigned m_cnt [4];
    longint unsigned m_rel [4];
    bit [3:0] m_en, m_mode, m_src, m_ie, m_pend;

    function automatic longint unsigned wmask(int t);
        return (t < 2) ? 64'h00FF_FFFF : 64'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] m_read(logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) begin
            for (int t = 0; t < 4; t++) begin
                r[2*t] = m_en[t]; r[2*t+1] = m_mode[t]; r[8+t] = m_src[t];
            end
        end else if (a == 8'h04) begin
            r = {24'd0, m_pend, m_ie};
        end
        for (int t = 0; t < 4; t++) begin
            if (a == 8'h10 + 8'(4*t)) r = 32'(m_rel[t]);
            if (a == 8'h20 + 8'(4*t)) r = 32'(m_cnt[t]);
        end
        return r;
    endfunction

    always @(posedge clk_i) begin
        bit [3:0] exp_now;
        bit st;
        longint unsigned old_rel;
        if (!rst_ni) begin
            for (int t = 0; t < 4; t++) begin m_cnt[t] = 0; m_rel[t] = 0; end
            m_en = 0; m_mode = 0; m_src = 0; m_ie = 0; m_pend = 0;
        end else begin
            exp_now = 0;
            for (int t = 0; t < 4; t++) begin
                old_rel = m_rel[t];
                st = m_src[t] ? tick_i : 1'b1;
                if (m_en[t] && st) begin
                    if (m_cnt[t] == 1) begin
                        exp_now[t] = 1'b1;
                        m_cnt[t] = m_mode[t] ? old_rel : 0;
                    end else if (m_cnt[t] == 0) begin
                        if (m_mode[t]) m_cnt[t] = old_rel;
                    end else begin
                        m_cnt[t] = m_cnt[t] - 1;
                    end
                end
                if (wr_i && addr_i == 8'h20 + 8'(4*t) && !m_en[t])
                    m_cnt[t] = longint'(wdata_i) & wmask(t);
                if (wr_i && addr_i == 8'h10 + 8'(4*t))
                    m_rel[t] = longint'(wdata_i) & wmask(t);
            end
            if (wr_i && addr_i == 8'h04) begin
                m_ie = wdata_i[3:0];
                m_pend = m_pend & ~wdata_i[7:4];
            end
            m_pend = m_pend | exp_now;
            if (wr_i && addr_i == 8'h00) begin
                for (int t = 0; t < 4; t++) begin
                    m_en[t] = wdata_i[2*t]; m_mode[t] = wdata_i[2*t+1]; m_src[t] = wdata_i[8+t];
                end
            end
        end
    end

    // per-cycle comparison against the model (R3 R8 and all register reads)
    always @(negedge clk_i) begin
        if (rst_ni && !done) begin
            checks++;
            if (rdata_o !== m_read(addr_i) || irq_o !== |(m_pend & m_ie)) begin
                failures++;
                $display("FAIL R3/R8 model compare addr=%h actual rdata=%h irq=%b expected rdata=%h irq=%b",
                         addr_i, rdata_o, irq_o, m_read(addr_i), |(m_pend & m_ie));
            end
        end
    end

    task automatic cyc(input logic [7:0] a, input logic w, input logic [31:0] d, input logic tk);
        addr_i = a; wr_i = w; wdata_i = d; tick_i = tk;
        @(posedge clk_i); #1;
        wr_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(a, 1'b1, d, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(8'h00, 1'b0, 32'h0, 1'b0);
    endtask

    task automatic chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr_i = a; wr_i = 1'b0; #2;
        checks++;
        if (rdata_o !== exp) begin
            failures++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata_o, exp);
        end
    endtask

    task automatic chk_irq(input string tag, input logic exp);
        checks++;
        if (irq_o !== exp) begin
            failures++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, exp);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #1 rst_ni = 1'b1;
        // R1 reset state
        chk("R1", 8'h00, 0); chk("R1", 8'h04, 0);
        for (int t = 0; t < 4; t++) begin
            chk("R1", 8'h10 + 8'(4*t), 0); chk("R1", 8'h20 + 8'(4*t), 0);
        end
        chk_irq("R1", 1'b0);
        chk("R2", 8'h3C, 0);

        // R2 widths
        wr(8'h20, 32'hFFFF_FFFF);
        chk("R2", 8'h20, 32'h00FF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        chk("R2", 8'h28, 32'hFFFF_FFFF);

        // R3 hold when disabled, decrement when enabled
        idle(3);
        chk("R3", 8'h28, 32'hFFFF_FFFF);
        wr(8'h00, 32'h10);
        idle(3);
        chk("R3", 8'h28, 32'hFFFF_FFFC);
        wr(8'h00, 32'h0);
        idle(2);
        chk("R3", 8'h28, 32'hFFFF_FFFB);

        // R9 count write ignored while enabled
        wr(8'h00, 32'h10);
        wr(8'h28, 32'd5);
        wr(8'h00, 32'h0);
        chk("R9", 8'h28, 32'hFFFF_FFF9);

        // R5 one-shot on channel 0, R6/R8 pending and irq
        wr(8'h20, 32'd3);
        wr(8'h04, 32'h01);
        wr(8'h00, 32'h01);
        idle(2);
        chk_irq("R8", 1'b0);
        idle(1);
        chk("R6", 8'h04, 32'h11);
        chk_irq("R8", 1'b1);
        idle(3);
        chk("R5", 8'h20, 32'h0);
        // R7 write-one-to-clear
        wr(8'h04, 32'h11);
        chk("R7", 8'h04, 32'h01);
        chk_irq("R7", 1'b0);
        wr(8'h00, 32'h0);

        // R4 periodic on channel 1, reload writable while running
        wr(8'h14, 32'd2);
        wr(8'h24, 32'd2);
        wr(8'h00, 32'h0C);
        idle(2);
        chk("R4", 8'h24, 32'd2);
        chk("R6", 8'h04, 32'h21);
        chk_irq("R8", 1'b0);
        idle(1);
        chk("R4", 8'h24, 32'd1);
        wr(8'h14, 32'd7);
        chk("R9", 8'h14, 32'd7);
        wr(8'h00, 32'h0);

        // R6 expiry and clear on the same edge: set wins
        wr(8'h24, 32'd1);
        wr(8'h14, 32'd1);
        wr(8'h04, 32'hF0);
        chk("R7", 8'h04, 32'h00);
        wr(8'h00, 32'h0C);
        for (int i = 0; i < 3; i++) begin
            wr(8'h04, 32'hF0);
            chk("R6", 8'h04, 32'h20);
        end
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hF0);
        chk("R7", 8'h04, 32'h00);

        // R10 external tick selection on channel 3
        wr(8'h2C, 32'd10);
        wr(8'h00, 32'h840);
        idle(3);
        chk("R10", 8'h2C, 32'd10);
        cyc(8'h00, 1'b0, 32'h0, 1'b1);
        chk("R10", 8'h2C, 32'd9);
        idle(2);
        chk("R10", 8'h2C, 32'd9);
        wr(8'h00, 32'h0);
        chk("R2", 8'h00, 32'h0);

        idle(2);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule